// File: doc/BRIEF.md
# Data Stack Top Buffer with Single-Word Spill and Fill

This block keeps the uppermost words of a processor's data stack in a small local register buffer, while everything deeper sits in external memory. The datapath issues push, pop and replace requests (replace removes two words and puts one back, as a two-operand ALU instruction does). The two uppermost entries are always driven straight out to the ALU, so operand reads never touch memory.

When a push finds the buffer full, the block writes the single deepest buffered word to memory first. When a pop finds the buffer empty, or a replace finds fewer than two buffered words, the block reads words back one at a time until enough are present. Each overflow or underflow moves exactly one word. Programs tend to stay near one stack depth, and under that pattern a one-word move stops the buffer from swinging between full and empty. The memory copy of the stack grows toward higher addresses. A memory pointer is incremented after each write and decremented before each read. While a transfer is under way, the ready output is low and no requests are taken.

Top module: `stk_cache`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied (`level` = 0), the memory pointer is set to zero and `ufl` is cleared. After reset, `rdy` is 1 and neither `mem_we` nor `mem_re` is asserted.
- R2: `op_code` 2'b01 is a push. When it is accepted with `level` < DEPTH, `op_data` becomes `tos`, the old `tos` becomes `nos`, `level` rises by one and `rdy` stays high.
- R3: A push accepted with `level` = DEPTH first spills one word. For one cycle, `mem_we` is high with `mem_wdata` equal to the deepest buffered word and `mem_addr` equal to the pointer. The pointer then increments and the push completes. `rdy` is low for exactly 2 cycles, and `level` ends at DEPTH.
- R4: `op_code` 2'b10 is a pop. When it is accepted with `level` ≥ 1, it removes `tos` without stalling. The word below moves up to `tos`, and `level` falls by one.
- R5: A pop accepted with `level` = 0 and a non-zero pointer first fills one word. The pointer decrements, and `mem_re` is high for one cycle with `mem_addr` equal to the new pointer. The memory returns data one cycle after `mem_re`; the block places that word at the bottom of the buffer and then completes the pop. `rdy` is low for exactly 3 cycles.
- R6: `op_code` 2'b11 is a replace. When it is accepted with `level` ≥ 2, `tos` becomes `op_data`, `nos` becomes the word that was third from the top, and `level` falls by one.
- R7: A replace accepted with `level` < 2 performs one fill per missing word, each as described in R5, until two words are buffered. It then completes. `rdy` is low for 3 cycles per fill.
- R8: A pop with no words anywhere, or a replace with fewer than two words in total, sets the sticky `ufl` flag and changes nothing else, without stalling. Only reset clears `ufl`.
- R9: Each spill or fill is a single memory cycle. `mem_we` and `mem_re` are never high together, and neither is high in two consecutive cycles.
- R10: Requests are taken only when `op_valid` and `rdy` are both high. `op_code` 2'b00, or `op_valid` low, leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 2 | 01 push, 10 pop, 11 replace, 00 none |
| op_data | input | WIDTH | Word pushed or replace result |
| rdy | output | 1 | High when a request can be accepted |
| tos | output | WIDTH | Top buffered word |
| nos | output | WIDTH | Second buffered word |
| level | output | $clog2(DEPTH+1) | Number of buffered words |
| ufl | output | 1 | Sticky underflow flag |
| mem_we | output | 1 | Spill write strobe |
| mem_re | output | 1 | Fill read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WIDTH | Spilled word |
| mem_rdata | input | WIDTH | Filled word, valid the cycle after `mem_re` |

## Verification
The hardest case to reach is a replace that arrives with an empty buffer while at least two words sit in memory. That case forces two back-to-back fills before the operation completes. A random walk seldom drains the buffer completely with memory still holding two words, so directed sequences produce it: they push DEPTH+2 words and then pop DEPTH. Separate random phases bias the walk upward and then downward, so that spills at full and fills at empty occur many times and in alternation. A reference stack kept in the bench checks every spilled word, every fill address and every stall length.

// File: rtl/stk_pkg.sv
// Shared encodings for the stack top buffer.
// Assumes: op codes are fixed by the datapath decoder.
package stk_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_REPL = 2'b11
    } stk_op_e;

    typedef enum logic [2:0] {
        BA_HOLD,
        BA_PUSH,
        BA_POP,
        BA_REPL,
        BA_FILL
    } buf_act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPILL,
        ST_FREQ,
        ST_FWAIT,
        ST_PEND
    } ctl_st_e;
endpackage

// File: rtl/stk_buf.sv
// Shifting register buffer; entry 0 is the top of stack.
// Assumes: the controller only requests a fill into an index below the level,
// and never pushes into a full buffer.
module stk_buf
    import stk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  buf_act_e                 act,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] fill_idx,
    output logic [WIDTH-1:0]         ent_top,
    output logic [WIDTH-1:0]         ent_next,
    output logic [WIDTH-1:0]         ent_deep
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][WIDTH-1:0] ent;
    logic [DEPTH-1:0][WIDTH-1:0] from_above;
    logic [DEPTH-1:0][WIDTH-1:0] from_below;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [WIDTH-1:0] q;

        if (i == 0) begin : g_top
            assign from_above[i] = wr_data;
        end else begin : g_mid
            assign from_above[i] = ent[i-1];
        end

        if (i == DEPTH - 1) begin : g_bot
            assign from_below[i] = '0;
        end else begin : g_up
            assign from_below[i] = ent[i+1];
        end

        // Update one entry according to the requested buffer action.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                case (act)
                    BA_PUSH: q <= from_above[i];
                    BA_POP:  q <= from_below[i];
                    BA_REPL: q <= (i == 0) ? wr_data : from_below[i];
                    BA_FILL: if (fill_idx == IDX_W'(i)) q <= wr_data;
                    default: q <= q;
                endcase
            end
        end

        assign ent[i] = q;
    end

    assign ent_top  = ent[0];
    assign ent_next = ent[1];
    assign ent_deep = ent[DEPTH-1];
endmodule

// File: rtl/stk_mptr.sv
// Memory-side stack pointer; memory stack grows upward.
// Assumes: inc and dec are never requested together.
module stk_mptr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_m1
);
    // Track the next free memory word.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= '0;
        else if (inc) sp <= sp + ADDR_W'(1);
        else if (dec) sp <= sp - ADDR_W'(1);
    end

    assign sp_m1 = sp - ADDR_W'(1);
endmodule

// File: rtl/stk_ctrl.sv
// Sequencer: decides execute, spill, fill or underflow for each request,
// keeps the buffer level and the sticky underflow flag.
// Assumes: memory returns read data one cycle after the read strobe.
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [1:0]                 op_code,
    input  logic [WIDTH-1:0]           op_data,
    input  logic [WIDTH-1:0]           mem_rdata,
    input  logic [ADDR_W-1:0]          sp,
    output logic                       rdy,
    output buf_act_e                   buf_act,
    output logic [WIDTH-1:0]           buf_wdata,
    output logic [$clog2(DEPTH)-1:0]   fill_idx,
    output logic                       sp_inc,
    output logic                       sp_dec,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ufl,
    output logic                       spill_go,
    output logic                       fill_go
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    ctl_st_e          st, st_nxt;
    stk_op_e          pend_op, cur_op;
    logic [WIDTH-1:0] pend_data, cur_data;
    logic [CNT_W-1:0] lvl, lvl_nxt;
    logic             ufl_q, ufl_set, latch;
    logic             sp_nz, sp_ge2, avail1, avail2;
    logic             short, need_spill, need_fill;

    // Select the request being worked on: fresh from the ports or held.
    always_comb begin
        if (st == ST_PEND) begin
            cur_op   = pend_op;
            cur_data = pend_data;
        end else begin
            cur_op   = op_valid ? stk_op_e'(op_code) : OP_NOP;
            cur_data = op_data;
        end
    end

    // Classify the current request against buffer and memory occupancy.
    always_comb begin
        sp_nz      = (sp != '0);
        sp_ge2     = (sp > ADDR_W'(1));
        avail1     = (lvl != '0) || sp_nz;
        avail2     = (lvl >= CNT_W'(2)) || ((lvl == CNT_W'(1)) && sp_nz) || sp_ge2;
        short      = ((cur_op == OP_POP) && !avail1) || ((cur_op == OP_REPL) && !avail2);
        need_spill = (cur_op == OP_PUSH) && (lvl == CNT_W'(DEPTH));
        need_fill  = ((cur_op == OP_POP) && (lvl == '0)) ||
                     ((cur_op == OP_REPL) && (lvl < CNT_W'(2)));
    end

    // Next-state, buffer action and level update.
    always_comb begin
        st_nxt    = st;
        buf_act   = BA_HOLD;
        buf_wdata = cur_data;
        lvl_nxt   = lvl;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        ufl_set   = 1'b0;
        latch     = 1'b0;
        case (st)
            ST_IDLE, ST_PEND: begin
                if (short) begin
                    ufl_set = 1'b1;
                    st_nxt  = ST_IDLE;
                end else if (need_spill) begin
                    st_nxt = ST_SPILL;
                    latch  = (st == ST_IDLE);
                end else if (need_fill) begin
                    st_nxt = ST_FREQ;
                    latch  = (st == ST_IDLE);
                end else begin
                    st_nxt = ST_IDLE;
                    case (cur_op)
                        OP_PUSH: begin
                            buf_act = BA_PUSH;
                            lvl_nxt = lvl + CNT_W'(1);
                        end
                        OP_POP: begin
                            buf_act = BA_POP;
                            lvl_nxt = lvl - CNT_W'(1);
                        end
                        OP_REPL: begin
                            buf_act = BA_REPL;
                            lvl_nxt = lvl - CNT_W'(1);
                        end
                        default: buf_act = BA_HOLD;
                    endcase
                end
            end
            ST_SPILL: begin
                lvl_nxt = lvl - CNT_W'(1);
                sp_inc  = 1'b1;
                st_nxt  = ST_PEND;
            end
            ST_FREQ: begin
                sp_dec = 1'b1;
                st_nxt = ST_FWAIT;
            end
            ST_FWAIT: begin
                buf_act   = BA_FILL;
                buf_wdata = mem_rdata;
                lvl_nxt   = lvl + CNT_W'(1);
                st_nxt    = ST_PEND;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State, level and underflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            lvl   <= '0;
            ufl_q <= 1'b0;
        end else begin
            st  <= st_nxt;
            lvl <= lvl_nxt;
            if (ufl_set) ufl_q <= 1'b1;
        end
    end

    // Hold a request that must wait for a memory transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_op   <= OP_NOP;
            pend_data <= '0;
        end else if (latch) begin
            pend_op   <= cur_op;
            pend_data <= cur_data;
        end
    end

    assign rdy      = (st == ST_IDLE);
    assign fill_idx = lvl[IDX_W-1:0];
    assign level    = lvl;
    assign ufl      = ufl_q;
    assign spill_go = (st == ST_SPILL);
    assign fill_go  = (st == ST_FREQ);
endmodule

// File: rtl/stk_cache.sv
// Top of the data stack buffer: joins sequencer, storage and memory pointer
// and drives the single-word memory port.
// Assumes: DEPTH >= 2; external memory is synchronous with one-cycle reads.
module stk_cache
    import stk_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [1:0]                 op_code,
    input  logic [WIDTH-1:0]           op_data,
    output logic                       rdy,
    output logic [WIDTH-1:0]           tos,
    output logic [WIDTH-1:0]           nos,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ufl,
    output logic                       mem_we,
    output logic                       mem_re,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [WIDTH-1:0]           mem_wdata,
    input  logic [WIDTH-1:0]           mem_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    buf_act_e           act;
    logic [WIDTH-1:0]   wdata, deep;
    logic [IDX_W-1:0]   fidx;
    logic               inc, dec, spill_go, fill_go;
    logic [ADDR_W-1:0]  sp, sp_m1;

    stk_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_data   (op_data),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .rdy       (rdy),
        .buf_act   (act),
        .buf_wdata (wdata),
        .fill_idx  (fidx),
        .sp_inc    (inc),
        .sp_dec    (dec),
        .level     (level),
        .ufl       (ufl),
        .spill_go  (spill_go),
        .fill_go   (fill_go)
    );

    stk_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .wr_data  (wdata),
        .fill_idx (fidx),
        .ent_top  (tos),
        .ent_next (nos),
        .ent_deep (deep)
    );

    stk_mptr #(.ADDR_W(ADDR_W)) mptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .dec   (dec),
        .sp    (sp),
        .sp_m1 (sp_m1)
    );

    assign mem_we    = spill_go;
    assign mem_re    = fill_go;
    assign mem_addr  = spill_go ? sp : sp_m1;
    assign mem_wdata = deep;
endmodule

// File: rtl/stk_cache_chk.sv
// Port-level temporal checks for the stack buffer, bound to every instance.
// Assumes: the bound instance uses the default op encoding.
module stk_cache_chk #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [1:0]                 op_code,
    input logic [WIDTH-1:0]           op_data,
    input logic                       rdy,
    input logic [WIDTH-1:0]           tos,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       ufl,
    input logic                       mem_we,
    input logic                       mem_re
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (level == '0 && !ufl && rdy)); // R1
    AST_PUSH_FAST: assert property (@(posedge clk) disable iff (!rst_n) (rdy && op_valid && op_code == 2'b01 && level < DEPTH) |=> (tos == $past(op_data) && rdy)); // R2
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level <= DEPTH); // R3
    AST_SPILL_FULL: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (level == DEPTH && !rdy)); // R3
    AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (rdy && op_valid && op_code == 2'b10 && level != '0) |=> (level == $past(level) - 1'b1)); // R4
    AST_FILL_LOW: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> (level < 2 && !rdy)); // R7
    AST_UFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ufl |=> ufl); // R8
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R9
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> (!mem_re && !mem_we)); // R9
endmodule

bind stk_cache stk_cache_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_data  (op_data),
    .rdy      (rdy),
    .tos      (tos),
    .level    (level),
    .ufl      (ufl),
    .mem_we   (mem_we),
    .mem_re   (mem_re)
);

// File: tb/stk_cache_tb.sv
module stk_cache_tb_top;
    localparam int CLK_P = 10;
    localparam int D     = 8;
    localparam int W     = 32;
    localparam int A     = 10;
    localparam int CW    = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = 2'b00;
    logic [W-1:0]  op_data = '0;
    logic          rdy, ufl, mem_we, mem_re;
    logic [W-1:0]  tos, nos, mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic [CW-1:0] level;
    logic [A-1:0]  mem_addr;

    int total = 0;
    int bad = 0;

    // Reference model: whole stack, depth, buffered count, sticky flag.
    logic [W-1:0] mstk [0:1023];
    logic [W-1:0] xmem [0:1023];
    int md = 0;
    int mc = 0;
    bit mufl = 0;

    int we_n, re_n, last_waddr, last_raddr;
    logic [W-1:0] last_wdata;

    always #(CLK_P/2) clk = ~clk;

    stk_cache #(.DEPTH(D), .WIDTH(W), .ADDR_W(A)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .rdy(rdy), .tos(tos), .nos(nos), .level(level),
        .ufl(ufl), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // External memory with one-cycle read latency, plus access monitor.
    always @(posedge clk) begin
        if (mem_we) begin
            xmem[mem_addr] <= mem_wdata;
            we_n <= we_n + 1;
            last_waddr <= int'(mem_addr);
            last_wdata <= mem_wdata;
        end
        if (mem_re) begin
            mem_rdata <= xmem[mem_addr];
            re_n <= re_n + 1;
            last_raddr <= int'(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_fills(input int op, input int c, input int d);
        if (op == 2 && d > 0 && c == 0) return 1;
        if (op == 3 && d >= 2 && c < 2) return 2 - c;
        return 0;
    endfunction

    task automatic check_state(input string req);
        chk(int'(level) == mc, req, level, mc);
        chk(ufl == mufl, req, ufl, mufl);
        if (mc >= 1) chk(tos == mstk[md-1], req, tos, mstk[md-1]);
        if (mc >= 2) chk(nos == mstk[md-2], req, nos, mstk[md-2]);
    endtask

    // Issue one request at a negedge, wait for rdy, compare with the model.
    task automatic do_op(input int op, input logic [W-1:0] data);
        int ms = md - mc;
        int exp_stall = 0, exp_we = 0, exp_re = 0, exp_waddr = 0, exp_raddr = 0;
        int nf, stalls;
        logic [W-1:0] exp_wdata = '0;
        string req;
        req = "R10";
        we_n = 0;
        re_n = 0;
        case (op)
            1: begin
                req = "R2";
                if (mc == D) begin
                    req = "R3";
                    exp_stall = 2; exp_we = 1; exp_waddr = ms; exp_wdata = mstk[ms];
                    mc--;
                end
                mstk[md] = data; md++; mc++;
            end
            2: begin
                req = "R4";
                if (md == 0) begin
                    req = "R8"; mufl = 1;
                end else begin
                    nf = ref_fills(2, mc, md);
                    if (nf > 0) begin
                        req = "R5"; exp_stall = 3; exp_re = 1; exp_raddr = ms - 1; mc++;
                    end
                    mc--; md--;
                end
            end
            3: begin
                req = "R6";
                if (md < 2) begin
                    req = "R8"; mufl = 1;
                end else begin
                    nf = ref_fills(3, mc, md);
                    if (nf > 0) begin
                        req = "R7"; exp_stall = 3 * nf; exp_re = nf; exp_raddr = ms - nf; mc += nf;
                    end
                    mc--; md--; mstk[md-1] = data;
                end
            end
            default: ;
        endcase
        op_valid = 1'b1;
        op_code  = op[1:0];
        op_data  = data;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 2'b00;
        stalls = 0;
        while (!rdy) begin
            stalls++;
            @(negedge clk);
        end
        chk(stalls == exp_stall, req, stalls, exp_stall);
        chk(we_n == exp_we, req, we_n, exp_we);
        chk(re_n == exp_re, req, re_n, exp_re);
        if (exp_we > 0) begin
            chk(last_waddr == exp_waddr, "R3", last_waddr, exp_waddr);
            chk(last_wdata == exp_wdata, "R3", last_wdata, exp_wdata);
        end
        if (exp_re > 0) chk(last_raddr == exp_raddr, "R5", last_raddr, exp_raddr);
        check_state(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        md = 0; mc = 0; mufl = 0;
        @(negedge clk);
        chk(level == '0, "R1", level, 0);
        chk(rdy == 1'b1, "R1", rdy, 1);
        chk(ufl == 1'b0, "R1", ufl, 0);
        chk(!mem_we && !mem_re, "R1", {mem_we, mem_re}, 0);
    endtask

    // Drive a request with op_valid low and confirm nothing moved.
    task automatic idle_garbage();
        op_valid = 1'b0;
        op_code  = 2'b01;
        op_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        op_code = 2'b00;
        check_state("R10");
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R8: underflow on an empty stack, then sticky
        do_op(2, '0);
        do_op(1, 32'h11);
        do_op(3, 32'h22);
        do_op(0, '0);
        idle_garbage();
        do_reset();
        // R3 / R5: spill on full, single fill on empty
        for (int i = 0; i < D + 1; i++) do_op(1, 32'h100 + i);
        for (int i = 0; i < D + 1; i++) do_op(2, '0);
        do_reset();
        // R7: replace with empty buffer needs two fills
        for (int i = 0; i < D + 2; i++) do_op(1, 32'h200 + i);
        for (int i = 0; i < D; i++) do_op(2, '0);
        do_op(3, 32'h3A3A);
        // R7: replace with one buffered word and memory behind it
        for (int i = 0; i < D + 2; i++) do_op(1, 32'h300 + i);
        for (int i = 0; i < D - 1; i++) do_op(2, '0);
        do_op(3, 32'h4B4B);
        idle_garbage();
        // Random phases: upward drift, downward drift, balanced
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1200; n++) begin
                int r = int'($urandom % 100);
                int op;
                if (ph == 0)      op = (r < 60) ? 1 : (r < 85) ? 2 : (r < 95) ? 3 : 0;
                else if (ph == 1) op = (r < 25) ? 1 : (r < 70) ? 2 : (r < 95) ? 3 : 0;
                else              op = (r < 42) ? 1 : (r < 75) ? 2 : (r < 95) ? 3 : 0;
                if (md > 900) op = 2;
                do_op(op, $urandom);
            end
        end
        // R1: reset clears level and flag after activity
        do_op(2, '0);
        do_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule